// File: doc/BRIEF.md
# ADC Conversion Start Sequencer

This block is the digital control loop around a successive-approximation converter. Once enabled, it counts out a programmable warm-up period and then accepts a conversion start from a software command bit or from a rising edge on an event line. Each start fixes the input channel and the accumulation count. The block then gathers one sample, or a power-of-two run of samples, from a sample engine that takes a fixed number of clock cycles per sample, and adds them into a wide sum.

When the last sample of a result arrives, the sum is copied to the result output and a sticky ready flag is raised. The ready flag is cleared by writing one to it. An interrupt request is the AND of the flag and two enables. In free-running mode, one software start begins an endless chain of back-to-back conversions. Dropping enable stops everything, and a fresh warm-up is then needed.

Top module: `adc_start_seq`

## Requirements
- R1: After enable rises, a start request is ignored until enable has been high for init_dly+1 clock cycles.
- R2: A software start pulse accepted at a clock edge sets busy in the same edge. A single-sample result completes CONV_LAT cycles later, and busy falls in that same edge.
- R3: The channel is latched at the start of each conversion. A change on chan_sel while busy has no effect on cur_chan or on the result until the next conversion begins.
- R4: acc_sel=k gives a result equal to the sum of 2^k consecutive samples, and takes 2^k*CONV_LAT cycles. Values of k above ACC_LOG (6) behave as ACC_LOG. The sum is sized for 64 full-scale 12-bit samples without overflow.
- R5: rdy_flag is set at every completed result, whatever the interrupt enables are.
- R6: irq is high exactly when rdy_flag, rdy_irq_en and glob_irq_en are all 1.
- R7: With evt_start_en=1, a rising edge on evt_in starts a conversion and sets busy. A held high level does not start another one. With evt_start_en=0, the event input is ignored.
- R8: With free_run=1, a software start begins a chain of conversions. Busy stays high and each completion sets rdy_flag. A new chan_sel value takes effect at the next completion. Clearing free_run lets the running conversion finish, and then busy falls.
- R9: Writing rdy_clr=1 clears rdy_flag. If a completion occurs in the same cycle, the flag stays set.
- R10: A start request while busy or during warm-up is dropped and not queued. It does not lengthen the running conversion.
- R11: Driving enable low clears busy in the next edge, aborting the conversion. A new warm-up is then required.
- R12: During reset, busy, rdy_flag, irq, result and cur_chan are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Converter enable |
| start_wr | input | 1 | Write-one pulse to the start command bit |
| init_dly | input | DLY_W | Warm-up length in cycles |
| chan_sel | input | CH_W | Requested input channel |
| free_run | input | 1 | Back-to-back conversion mode |
| evt_start_en | input | 1 | Allow event-triggered start |
| evt_in | input | 1 | Event line, rising edge starts |
| acc_sel | input | SEL_W | Log2 of samples per result |
| rdy_irq_en | input | 1 | Ready interrupt enable |
| glob_irq_en | input | 1 | Global interrupt enable |
| rdy_clr | input | 1 | Write-one-to-clear for the ready flag |
| smp_data | input | SMP_W | Sample engine value for cur_chan |
| busy | output | 1 | Start command bit readback |
| cur_chan | output | CH_W | Channel being converted |
| result | output | SMP_W+ACC_LOG | Last completed sum |
| rdy_flag | output | 1 | Sticky result-ready flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench presses starts into the last warm-up cycle and into a running conversion. A design that counted one cycle short, or that queued the request, would show busy at a point where it must be low. It changes the channel mid-conversion and drops free-running mode mid-chain. A design that switched channel too early would return the wrong channel's sum, and one that ignored the mode change would keep busy stuck high. It also aims a clear at the exact completion cycle, where a design that let the clear win would lose the flag. Finally it runs a 64-sample full-scale sum and an out-of-range count, which would expose a truncated accumulator or a missing clamp.

// File: rtl/adc_start_seq.sv
module adc_start_seq #(
  parameter int SMP_W    = 12,
  parameter int ACC_LOG  = 6,
  parameter int CH_W     = 4,
  parameter int DLY_W    = 8,
  parameter int CONV_LAT = 4,
  parameter int SEL_W    = $clog2(ACC_LOG + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     start_wr,
  input  logic [DLY_W-1:0]         init_dly,
  input  logic [CH_W-1:0]          chan_sel,
  input  logic                     free_run,
  input  logic                     evt_start_en,
  input  logic                     evt_in,
  input  logic [SEL_W-1:0]         acc_sel,
  input  logic                     rdy_irq_en,
  input  logic                     glob_irq_en,
  input  logic                     rdy_clr,
  input  logic [SMP_W-1:0]         smp_data,
  output logic                     busy,
  output logic [CH_W-1:0]          cur_chan,
  output logic [SMP_W+ACC_LOG-1:0] result,
  output logic                     rdy_flag,
  output logic                     irq
);
  localparam int RES_W = SMP_W + ACC_LOG;
  localparam int LAT_W = $clog2(CONV_LAT + 1);

  logic [DLY_W-1:0]   wu_cnt;
  logic               warm;
  logic               evt_q;
  logic [LAT_W-1:0]   lat_cnt;
  logic [ACC_LOG-1:0] smp_cnt;
  logic [SEL_W-1:0]   acc_q;
  logic [RES_W-1:0]   acc;

  wire               evt_rise = evt_in & ~evt_q;
  wire               trig     = enable & warm & ~busy & (start_wr | (evt_start_en & evt_rise));
  wire               smp_tick = enable & busy & (lat_cnt == LAT_W'(CONV_LAT - 1));
  wire [ACC_LOG-1:0] smp_last = ACC_LOG'((32'd1 << acc_q) - 32'd1);
  wire               fin      = smp_tick & (smp_cnt == smp_last);
  wire [RES_W-1:0]   acc_nxt  = acc + RES_W'(smp_data);
  wire [SEL_W-1:0]   acc_eff  = (acc_sel > SEL_W'(ACC_LOG)) ? SEL_W'(ACC_LOG) : acc_sel;

  assign irq = rdy_flag & rdy_irq_en & glob_irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wu_cnt   <= '0;
      warm     <= 1'b0;
      evt_q    <= 1'b0;
      busy     <= 1'b0;
      lat_cnt  <= '0;
      smp_cnt  <= '0;
      acc_q    <= '0;
      acc      <= '0;
      cur_chan <= '0;
      result   <= '0;
    end else begin
      evt_q <= evt_in;
      if (!enable) begin
        wu_cnt  <= '0;
        warm    <= 1'b0;
        busy    <= 1'b0;
        lat_cnt <= '0;
      end else begin
        if (!warm) begin
          if (wu_cnt == init_dly) warm <= 1'b1;
          else                    wu_cnt <= wu_cnt + 1'b1;
        end
        if (trig) begin
          busy     <= 1'b1;
          cur_chan <= chan_sel;
          acc_q    <= acc_eff;
          lat_cnt  <= '0;
          smp_cnt  <= '0;
          acc      <= '0;
        end else if (busy) begin
          if (smp_tick) begin
            lat_cnt <= '0;
            if (fin) begin
              result  <= acc_nxt;
              acc     <= '0;
              smp_cnt <= '0;
              if (free_run) begin
                cur_chan <= chan_sel;
                acc_q    <= acc_eff;
              end else begin
                busy <= 1'b0;
              end
            end else begin
              smp_cnt <= smp_cnt + 1'b1;
              acc     <= acc_nxt;
            end
          end else begin
            lat_cnt <= lat_cnt + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdy_flag <= 1'b0;
    else if (fin)     rdy_flag <= 1'b1;
    else if (rdy_clr) rdy_flag <= 1'b0;
  end
endmodule

module adc_start_seq_chk #(
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            busy,
  input logic            warm,
  input logic            fin,
  input logic [CH_W-1:0] cur_chan,
  input logic            rdy_flag,
  input logic            irq
);
  p_start_after_warm_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(warm));

  p_chan_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(fin)) |-> $stable(cur_chan));

  p_flag_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> rdy_flag);

  p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rdy_flag);

  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy);
endmodule

bind adc_start_seq adc_start_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .busy(busy), .warm(warm),
  .fin(fin), .cur_chan(cur_chan), .rdy_flag(rdy_flag), .irq(irq)
);

// File: tb/sim_adc_start_seq.sv
module sim_adc_start_seq;
  localparam int L = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 0, start_wr = 0, free_run = 0, evt_start_en = 0, evt_in = 0;
  logic        rdy_irq_en = 0, glob_irq_en = 0, rdy_clr = 0;
  logic [7:0]  init_dly = 0;
  logic [3:0]  chan_sel = 0;
  logic [2:0]  acc_sel = 0;
  logic [11:0] smp_data;
  logic        busy, rdy_flag, irq;
  logic [3:0]  cur_chan;
  logic [17:0] result;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  function automatic logic [11:0] smp_of(input logic [3:0] ch);
    return (ch == 4'd15) ? 12'd4095 : 12'(100 + 37 * ch);
  endfunction
  assign smp_data = smp_of(cur_chan);

  adc_start_seq u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_wr(start_wr),
    .init_dly(init_dly), .chan_sel(chan_sel), .free_run(free_run),
    .evt_start_en(evt_start_en), .evt_in(evt_in), .acc_sel(acc_sel),
    .rdy_irq_en(rdy_irq_en), .glob_irq_en(glob_irq_en), .rdy_clr(rdy_clr),
    .smp_data(smp_data), .busy(busy), .cur_chan(cur_chan), .result(result),
    .rdy_flag(rdy_flag), .irq(irq)
  );

  // {chan, acc_sel, expected sum}
  localparam logic [24:0] VEC [6] = '{
    {4'd3,  3'd0, 18'd211},
    {4'd12, 3'd3, 18'd4352},
    {4'd9,  3'd1, 18'd866},
    {4'd15, 3'd6, 18'd262080},
    {4'd0,  3'd7, 18'd6400},
    {4'd5,  3'd2, 18'd1140}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start_wr = 1;
    @(negedge clk) start_wr = 0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic clr();
    @(negedge clk) rdy_clr = 1;
    @(negedge clk) rdy_clr = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R12 busy", busy, 0);
    chk("R12 rdy", rdy_flag, 0);
    chk("R12 irq", irq, 0);
    chk("R12 result", result, 0);
    chk("R12 chan", cur_chan, 0);
    rst_n = 1;

    // R1 warm-up
    init_dly = 5;
    @(negedge clk) begin enable = 1; start_wr = 1; end
    repeat (6) @(negedge clk);
    start_wr = 0;
    chk("R1 start in warm-up ignored", busy, 0);
    do_start();
    chk("R2 busy after start", busy, 1);
    wait_idle(n);
    chk("R2 latency", n, L);
    chk("R5 ready set", rdy_flag, 1);
    chk("R2 result", result, 100);
    clr();
    chk("R9 clear", rdy_flag, 0);

    // R4 table of channels and accumulation counts
    for (int i = 0; i < 6; i++) begin
      int k;
      chan_sel = VEC[i][24:21];
      acc_sel  = VEC[i][20:18];
      k = (acc_sel > 6) ? 6 : int'(acc_sel);
      do_start();
      chk("R3 channel latched", cur_chan, VEC[i][24:21]);
      wait_idle(n);
      chk("R4 duration", n, (1 << k) * L);
      chk("R4 sum", result, VEC[i][17:0]);
      chk("R5 flag with irq off", rdy_flag, 1);
      chk("R6 irq off", irq, 0);
      clr();
    end

    // R3 deferred channel change
    chan_sel = 3; acc_sel = 1;
    do_start();
    @(negedge clk) chan_sel = 7;
    chk("R3 chan held", cur_chan, 3);
    wait_idle(n);
    chk("R3 old channel result", result, 422);
    do_start();
    chk("R3 new channel next", cur_chan, 7);
    wait_idle(n);
    chk("R3 new channel result", result, 718);

    // R10 start while busy
    chan_sel = 1; acc_sel = 0;
    do_start();
    @(negedge clk) start_wr = 1;
    @(negedge clk) start_wr = 0;
    wait_idle(n);
    chk("R10 not lengthened", n, L - 2);
    @(negedge clk);
    chk("R10 not queued", busy, 0);

    // R6 interrupt gating
    rdy_irq_en = 0; glob_irq_en = 1; #1;
    chk("R6 local off", irq, 0);
    rdy_irq_en = 1; glob_irq_en = 0; #1;
    chk("R6 global off", irq, 0);
    glob_irq_en = 1; #1;
    chk("R6 both on", irq, 1);
    clr();
    chk("R6 cleared flag", irq, 0);
    rdy_irq_en = 0; glob_irq_en = 0;

    // R9 set wins over clear
    chan_sel = 2;
    @(negedge clk) start_wr = 1;
    @(negedge clk) start_wr = 0;
    repeat (L - 1) @(negedge clk);
    rdy_clr = 1;
    @(negedge clk) rdy_clr = 0;
    chk("R9 set wins", rdy_flag, 1);
    chk("R9 done", busy, 0);
    clr();

    // R7 event start
    @(negedge clk) evt_in = 1;
    @(negedge clk);
    chk("R7 event ignored when disabled", busy, 0);
    evt_in = 0; evt_start_en = 1; chan_sel = 5;
    @(negedge clk) evt_in = 1;
    @(negedge clk);
    chk("R7 event starts", busy, 1);
    wait_idle(n);
    chk("R7 result", result, 285);
    repeat (3) @(negedge clk);
    chk("R7 level no retrigger", busy, 0);
    evt_in = 0; evt_start_en = 0;
    clr();

    // R8 free-running
    chan_sel = 2; free_run = 1;
    do_start();
    @(negedge clk) chan_sel = 4;
    repeat (L - 1) @(negedge clk);
    chk("R8 busy stays", busy, 1);
    chk("R8 first ready", rdy_flag, 1);
    chk("R8 first result", result, 174);
    chk("R8 channel switched", cur_chan, 4);
    clr();
    repeat (L - 2) @(negedge clk);
    chk("R8 second ready", rdy_flag, 1);
    chk("R8 second result", result, 248);
    free_run = 0;
    wait_idle(n);
    chk("R8 stops after current", n, L);
    @(negedge clk);
    chk("R8 idle", busy, 0);
    clr();

    // R11 abort on disable
    init_dly = 2; chan_sel = 1; acc_sel = 3;
    do_start();
    repeat (3) @(negedge clk);
    enable = 0;
    @(negedge clk);
    chk("R11 abort", busy, 0);
    enable = 1; start_wr = 1;
    repeat (3) @(negedge clk);
    start_wr = 0;
    chk("R11 rewarm required", busy, 0);
    do_start();
    chk("R11 restart", busy, 1);
    wait_idle(n);
    chk("R11 full duration", n, 8 * L);
    chk("R11 result", result, 1096);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule